// File: doc/BRIEF.md
# I2C Master Byte Transfer Engine

This block is the bit engine of a master-side two-wire serial port. For each transfer it moves a programmable number of data bits across SDA, most significant bit first, with one SCL period per bit. An extra acknowledge clock can be added after the data bits. It sends when the direction input selects transmit and receives otherwise. A separate clock generator supplies a one-cycle phase strobe. Each strobe moves SCL by one half-period while a transfer is running.

A 3-bit transfer-length register sets the data bit count. It is written through `cntWr`/`cntCode`, and `busStart` clears it to zero, which selects eight bits. This way the address byte that follows a start condition always has full length. The value written then carries over to later transfers. When a transfer ends, the engine raises `xferDone` for one cycle. `rxByte` then holds the sampled data bits, and `ackSeen` holds the acknowledge level returned by the receiver.

Top module: `i2cm_byte_engine`

## Requirements
- R1: Length code 000 gives 8 data bits. A code k from 001 to 111 gives k data bits. The code is captured when a transfer is accepted.
- R2: When transmitting, bit 7 of `txByte` goes out first, then the lower bits in order. `sdaPullLow`=1 pulls SDA low and 0 releases it.
- R3: `sdaPullLow` changes only while SCL is low. It stays constant for the whole of every SCL high phase.
- R4: Out of reset and between transfers, SCL is held low. During a transfer each `sclStrobe` toggles SCL. Strobes that arrive while idle have no effect.
- R5: With `ackMode`=1, exactly one SCL pulse follows the data bits. With `ackMode`=0, the transfer ends after the last data bit and there is no extra pulse.
- R6: As transmitter, the engine releases SDA during the acknowledge clock and stores the SDA level seen at its rising edge in `ackSeen` (0 means acknowledged). A receive transfer leaves `ackSeen` unchanged.
- R7: As receiver, the engine pulls SDA low during the acknowledge clock.
- R8: After a transfer, `rxByte` holds the n SDA levels sampled at the data rising edges, right-aligned with the first bit highest. The bits above them are 0.
- R9: `busStart` clears the length code to 000, and it takes priority over a `cntWr` in the same cycle. In all other cases the code keeps its value until it is written.
- R10: `xferDone` is high for exactly one cycle. That cycle is the first one in which SCL is low after the final pulse.
- R11: A `startReq` during a transfer is ignored. A `startReq` raised in the `xferDone` cycle is accepted.
- R12: Reset leaves SCL low, SDA released, `rxByte`=0, `ackSeen`=1 and `xferDone`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busStart | input | 1 | Start condition seen; clears the length code |
| cntWr | input | 1 | Write strobe for the length code |
| cntCode | input | 3 | Length code value to write |
| startReq | input | 1 | Request to begin a transfer |
| recvMode | input | 1 | 1 = receive, 0 = transmit |
| ackMode | input | 1 | 1 = add an acknowledge clock |
| txByte | input | 8 | Data to transmit |
| sclStrobe | input | 1 | One-cycle SCL half-period strobe |
| sdaIn | input | 1 | SDA level on the bus |
| sdaPullLow | output | 1 | Open-drain SDA pull-down enable |
| sclOut | output | 1 | SCL level |
| rxByte | output | 8 | Sampled data bits |
| ackSeen | output | 1 | Acknowledge level sampled as transmitter |
| xferDone | output | 1 | End-of-transfer pulse |

## Verification
Two things can fall in the same cycle: the end of one transfer and the request for the next. In one scenario the driver raises `startReq` for a receive transfer in the very cycle that `xferDone` is high after a transmit transfer. The scoreboard then checks both items in order, comparing pulse counts and sampled levels for each. A second case puts `busStart` and `cntWr` in the same cycle. The full 8-bit length of the transfer that follows shows that the clear took priority.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_DATA = 2'd1,
    PH_ACK  = 2'd2
  } phase_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;       // transfer accepted: capture operands
    logic sampleData; // SCL rising in a data bit
    logic sampleAck;  // SCL rising in the acknowledge clock
    logic shiftNext;  // SCL falling with data bits remaining
    logic inData;     // level: data phase active
    logic inAck;      // level: acknowledge phase active
  } xferCtl_t;

endpackage

// File: rtl/i2cm_ctrl.sv
module i2cm_ctrl
  import i2cm_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int CODE_W = $clog2(DATA_W),
  localparam int CNT_W = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic              ackMode,
  input  logic              sclStrobe,
  input  logic [CODE_W-1:0] codeNow,
  output xferCtl_t          ctl,
  output logic              sclOut,
  output logic              xferDone
);

  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DATA_W);

  phase_e            phase;
  logic [CNT_W-1:0]  bitsLeft;
  logic              ackLat;
  logic              sclReg;
  logic              doneReg;

  logic accept, tick, riseNow, fallNow, lastBit, finishNow;
  logic [CNT_W-1:0] startCnt;

  always_comb begin
    accept    = (phase == PH_IDLE) && startReq;
    tick      = sclStrobe && (phase != PH_IDLE);
    riseNow   = tick && !sclReg;
    fallNow   = tick && sclReg;
    lastBit   = (bitsLeft == CNT_W'(1));
    startCnt  = (codeNow == '0) ? FULL_CNT : CNT_W'(codeNow);
    finishNow = fallNow && ((phase == PH_ACK) ||
                            ((phase == PH_DATA) && lastBit && !ackLat));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase    <= PH_IDLE;
      bitsLeft <= '0;
      ackLat   <= 1'b0;
      sclReg   <= 1'b0;
      doneReg  <= 1'b0;
    end else begin
      doneReg <= finishNow;
      if (riseNow)      sclReg <= 1'b1;
      else if (fallNow) sclReg <= 1'b0;
      if (accept) begin
        phase    <= PH_DATA;
        bitsLeft <= startCnt;
        ackLat   <= ackMode;
      end else if (fallNow) begin
        unique case (phase)
          PH_DATA: begin
            if (!lastBit)    bitsLeft <= bitsLeft - CNT_W'(1);
            else if (ackLat) phase <= PH_ACK;
            else             phase <= PH_IDLE;
          end
          PH_ACK:  phase <= PH_IDLE;
          default: phase <= PH_IDLE;
        endcase
      end
    end
  end

  always_comb begin
    ctl.load       = accept;
    ctl.sampleData = riseNow && (phase == PH_DATA);
    ctl.sampleAck  = riseNow && (phase == PH_ACK);
    ctl.shiftNext  = fallNow && (phase == PH_DATA) && !lastBit;
    ctl.inData     = (phase == PH_DATA);
    ctl.inAck      = (phase == PH_ACK);
  end

  assign sclOut   = sclReg;
  assign xferDone = doneReg;

  // R4: SCL moves only on a strobe
  a_r4_scl_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !sclStrobe |=> $stable(sclOut));

  // R4: SCL is low whenever the engine is idle
  a_r4_idle_low: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_IDLE) |-> !sclOut);

  // R10: done lasts one cycle
  a_r10_done_single: assert property (@(posedge clk) disable iff (!rstN)
    xferDone |=> !xferDone);

  // R10: done comes right after the final falling edge
  a_r10_done_after_fall: assert property (@(posedge clk) disable iff (!rstN)
    xferDone |-> (!sclOut && $past(sclOut)));

  // R11: a start request during a transfer does not reload the bit counter
  a_r11_start_ignored: assert property (@(posedge clk) disable iff (!rstN)
    ((phase != PH_IDLE) && startReq && !sclStrobe) |=> $stable(bitsLeft));

  // R1: remaining count stays in range during a transfer
  a_r1_count_range: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_DATA) |-> ((bitsLeft != '0) && (bitsLeft <= FULL_CNT)));

endmodule

// File: rtl/i2cm_datapath.sv
module i2cm_datapath
  import i2cm_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int CODE_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busStart,
  input  logic              cntWr,
  input  logic [CODE_W-1:0] cntCode,
  input  logic              recvMode,
  input  logic [DATA_W-1:0] txByte,
  input  logic              sdaIn,
  input  xferCtl_t          ctl,
  output logic [CODE_W-1:0] codeNow,
  output logic              sdaPullLow,
  output logic [DATA_W-1:0] rxByte,
  output logic              ackSeen
);

  logic [CODE_W-1:0] codeReg;
  logic [DATA_W-1:0] txShift;
  logic [DATA_W-1:0] rxShift;
  logic              recvLat;
  logic              ackReg;

  // length code register: start condition wins over a write
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         codeReg <= '0;
    else if (busStart) codeReg <= '0;
    else if (cntWr)    codeReg <= cntCode;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= '0;
      rxShift <= '0;
      recvLat <= 1'b0;
      ackReg  <= 1'b1;
    end else begin
      if (ctl.load) begin
        txShift <= txByte;
        rxShift <= '0;
        recvLat <= recvMode;
      end else begin
        if (ctl.shiftNext)  txShift <= {txShift[DATA_W-2:0], 1'b0};
        if (ctl.sampleData) rxShift <= {rxShift[DATA_W-2:0], sdaIn};
        if (ctl.sampleAck && !recvLat) ackReg <= sdaIn;
      end
    end
  end

  always_comb begin
    if (ctl.inData)     sdaPullLow = !recvLat && !txShift[DATA_W-1];
    else if (ctl.inAck) sdaPullLow = recvLat;
    else                sdaPullLow = 1'b0;
  end

  assign codeNow = codeReg;
  assign rxByte  = rxShift;
  assign ackSeen = ackReg;

  // R9: a start condition leaves the code at 000
  a_r9_code_cleared: assert property (@(posedge clk) disable iff (!rstN)
    $past(busStart) |-> (codeNow == '0));

  // R9: without a write or start the code holds
  a_r9_code_kept: assert property (@(posedge clk) disable iff (!rstN)
    (!busStart && !cntWr) |=> $stable(codeNow));

  // R6: receive transfers never touch the stored acknowledge
  a_r6_rx_keeps_ack: assert property (@(posedge clk) disable iff (!rstN)
    (recvLat && !ctl.load) |=> $stable(ackSeen));

  // R7: master never pulls SDA during receive data bits
  a_r7_rx_data_released: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.inData && recvLat) |-> !sdaPullLow);

endmodule

// File: rtl/i2cm_byte_engine.sv
module i2cm_byte_engine
  import i2cm_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int CODE_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busStart,
  input  logic              cntWr,
  input  logic [CODE_W-1:0] cntCode,
  input  logic              startReq,
  input  logic              recvMode,
  input  logic              ackMode,
  input  logic [DATA_W-1:0] txByte,
  input  logic              sclStrobe,
  input  logic              sdaIn,
  output logic              sdaPullLow,
  output logic              sclOut,
  output logic [DATA_W-1:0] rxByte,
  output logic              ackSeen,
  output logic              xferDone
);

  xferCtl_t          ctl;
  logic [CODE_W-1:0] codeNow;

  i2cm_ctrl #(.DATA_W(DATA_W)) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .startReq  (startReq),
    .ackMode   (ackMode),
    .sclStrobe (sclStrobe),
    .codeNow   (codeNow),
    .ctl       (ctl),
    .sclOut    (sclOut),
    .xferDone  (xferDone)
  );

  i2cm_datapath #(.DATA_W(DATA_W)) uData (
    .clk        (clk),
    .rstN       (rstN),
    .busStart   (busStart),
    .cntWr      (cntWr),
    .cntCode    (cntCode),
    .recvMode   (recvMode),
    .txByte     (txByte),
    .sdaIn      (sdaIn),
    .ctl        (ctl),
    .codeNow    (codeNow),
    .sdaPullLow (sdaPullLow),
    .rxByte     (rxByte),
    .ackSeen    (ackSeen)
  );

  // R3: SDA is frozen across every SCL high phase
  a_r3_sda_stable_high: assert property (@(posedge clk) disable iff (!rstN)
    (sclOut && $past(sclOut)) |-> $stable(sdaPullLow));

endmodule

// File: tb/tb_i2cm_byte_engine.sv
`timescale 1ns/1ps
module tb_i2cm_byte_engine;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       busStart = 1'b0, cntWr = 1'b0;
  logic [2:0] cntCode = '0;
  logic       startReq = 1'b0, recvMode = 1'b0, ackMode = 1'b0;
  logic [7:0] txByte = '0;
  logic       sclStrobe = 1'b0;
  logic       slaveLow = 1'b0;
  logic       sdaLine;
  logic       sdaPullLow, sclOut, ackSeen, xferDone;
  logic [7:0] rxByte;

  int checks = 0, failures = 0;
  logic lastAck = 1'b1;

  typedef struct {
    int         pulses;
    logic [15:0] line;
    logic [7:0]  rx;
    logic        ack;
  } exp_t;
  exp_t q[$];

  always #2.5 clk = ~clk;   // 200 MHz

  assign sdaLine = !(sdaPullLow || slaveLow);

  i2cm_byte_engine dut (
    .clk(clk), .rstN(rstN), .busStart(busStart), .cntWr(cntWr),
    .cntCode(cntCode), .startReq(startReq), .recvMode(recvMode),
    .ackMode(ackMode), .txByte(txByte), .sclStrobe(sclStrobe),
    .sdaIn(sdaLine), .sdaPullLow(sdaPullLow), .sclOut(sclOut),
    .rxByte(rxByte), .ackSeen(ackSeen), .xferDone(xferDone)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic int codeBits(input logic [2:0] c);  // R1
    return (c == 3'd0) ? 8 : int'(c);
  endfunction

  // ---------------- monitor ----------------
  int          pulseCnt = 0;
  logic [15:0] capLine = '0;
  logic        prevScl = 1'b0;

  always @(negedge clk) begin
    if (rstN) begin
      if (sclOut && !prevScl) begin
        pulseCnt++;
        capLine = {capLine[14:0], sdaLine};
      end
      if (xferDone) begin
        if (q.size() == 0) begin
          check("R10_unexpected_done", 1, 0);
        end else begin
          exp_t e;
          e = q.pop_front();
          check("R5 pulse count", pulseCnt, e.pulses);
          check("R2 bus levels", capLine, e.line);
          check("R8 rxByte", rxByte, e.rx);
          check("R6 ackSeen", ackSeen, e.ack);
          check("R10 done after fall", {sclOut, prevScl}, 2'b01);
        end
        pulseCnt = 0;
        capLine  = '0;
      end
    end
    prevScl = sclOut;
  end

  // ---------------- driver ----------------
  task automatic strobeOnce();
    repeat (2) @(negedge clk);
    sclStrobe = 1'b1;
    @(negedge clk);
    sclStrobe = 1'b0;
  endtask

  task automatic beginXfer(input logic recv, input logic ack, input logic [7:0] tx,
                           input logic [7:0] rxPat, input logic slvAck, input int n);
    exp_t e;
    e.pulses = n + (ack ? 1 : 0);
    e.line = '0;
    e.rx = '0;
    for (int i = 0; i < n; i++) begin
      logic b;
      b = recv ? rxPat[n-1-i] : tx[7-i];
      e.line = {e.line[14:0], b};
      e.rx   = {e.rx[6:0], b};
    end
    if (ack) e.line = {e.line[14:0], recv ? 1'b0 : slvAck};
    if (ack && !recv) lastAck = slvAck;
    e.ack = lastAck;
    q.push_back(e);
    recvMode = recv; ackMode = ack; txByte = tx;
    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
  endtask

  task automatic clockBits(input logic recv, input logic ack, input logic [7:0] rxPat,
                           input logic slvAck, input int n, input bit poke);
    int total;
    total = n + (ack ? 1 : 0);
    for (int i = 0; i < total; i++) begin
      if (i < n) slaveLow = recv ? !rxPat[n-1-i] : 1'b0;
      else       slaveLow = recv ? 1'b0 : !slvAck;
      if (poke && i == 1) begin      // R11: request mid-transfer
        startReq = 1'b1; txByte = ~txByte; recvMode = ~recvMode;
        @(negedge clk);
        startReq = 1'b0;
        sclStrobe = 1'b1;
        @(negedge clk);
        sclStrobe = 1'b0;
      end else begin
        strobeOnce();
      end
      strobeOnce();
    end
    slaveLow = 1'b0;
  endtask

  task automatic idleStrobes();     // R4/R5: strobes between transfers do nothing
    strobeOnce();
    check("R4 idle scl", sclOut, 0);
    strobeOnce();
    check("R4 idle scl", sclOut, 0);
  endtask

  task automatic fullXfer(input logic [2:0] code, input logic recv, input logic ack,
                          input logic [7:0] tx, input logic [7:0] rxPat,
                          input logic slvAck, input bit poke);
    int n;
    n = codeBits(code);
    beginXfer(recv, ack, tx, rxPat, slvAck, n);
    clockBits(recv, ack, rxPat, slvAck, n, poke);
    repeat (2) @(negedge clk);
    idleStrobes();
  endtask

  task automatic writeCode(input logic [2:0] c, input logic withStart);
    cntWr = 1'b1; cntCode = c; busStart = withStart;
    @(negedge clk);
    cntWr = 1'b0; busStart = 1'b0;
  endtask

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12 reset state
    check("R12 scl", sclOut, 0);
    check("R12 sda", sdaPullLow, 0);
    check("R12 rxByte", rxByte, 0);
    check("R12 ackSeen", ackSeen, 1);
    check("R12 done", xferDone, 0);
    rstN = 1'b1;
    @(negedge clk);
    idleStrobes();

    // R1: default code 000 -> 8 bits, transmit with ack, slave acks
    fullXfer(3'd0, 1'b0, 1'b1, 8'hA5, 8'h00, 1'b0, 1'b0);
    // R1/R2: 3-bit transmit, no ack clock (R5)
    writeCode(3'd3, 1'b0);
    fullXfer(3'd3, 1'b0, 1'b0, 8'hC0, 8'h00, 1'b0, 1'b0);
    // R9 retention: no rewrite, 3-bit receive with ack (R7)
    fullXfer(3'd3, 1'b1, 1'b1, 8'h00, 8'h05, 1'b0, 1'b0);
    // R9: start condition clears code -> 8-bit receive
    busStart = 1'b1; @(negedge clk); busStart = 1'b0;
    fullXfer(3'd0, 1'b1, 1'b1, 8'h00, 8'h3C, 1'b0, 1'b0);
    // R9: start beats a write in the same cycle
    writeCode(3'd5, 1'b1);
    fullXfer(3'd0, 1'b0, 1'b0, 8'h96, 8'h00, 1'b0, 1'b0);
    // R11: mid-transfer request ignored; 7 bits, slave NACK (R6)
    writeCode(3'd7, 1'b0);
    fullXfer(3'd7, 1'b0, 1'b1, 8'h6B, 8'h00, 1'b1, 1'b1);
    // R11: back-to-back start in the done cycle
    writeCode(3'd1, 1'b0);
    beginXfer(1'b0, 1'b1, 8'h80, 8'h00, 1'b0, 1);
    clockBits(1'b0, 1'b1, 8'h00, 1'b0, 1, 1'b0);
    check("R11 done cycle", xferDone, 1);
    beginXfer(1'b1, 1'b1, 8'h00, 8'h01, 1'b0, 1);
    clockBits(1'b1, 1'b1, 8'h01, 1'b0, 1, 1'b0);
    repeat (2) @(negedge clk);
    idleStrobes();
    // R6: receive leaves ackSeen; 4-bit receive, no ack
    writeCode(3'd4, 1'b0);
    fullXfer(3'd4, 1'b1, 1'b0, 8'h00, 8'h0A, 1'b0, 1'b0);

    repeat (4) @(negedge clk);
    check("R10 all transfers done", q.size(), 0);
    check("R5 no stray pulses", pulseCnt, 0);
    finishRun();
  end

endmodule